// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer whose counting logic lives entirely on its own slow clock, so a stalled or failed bus clock cannot silence it. A 12-bit down-counter steps once per prescaler period. When a step is due while the counter already reads zero, the block raises a one-cycle reset request and the counter restarts from the programmed reload value. The timeout is therefore (reload + 1) × divide ratio watchdog cycles. With a 32 kHz watchdog clock this spans about 125 us (reload 0, divide by 4) up to about 32.7 s (reload 0xFFF, divide by 256).

Software reaches the block only through a small register port on the bus clock. Commands are 16-bit key values written to a key register. One key starts the timer, one reloads the counter, and one opens the prescaler and reload registers for writing. The timer can also be started by a hardware strap input. Once started, the timer cannot be stopped short of a watchdog-domain reset. Prescaler and reload values travel into the watchdog domain through a request/acknowledge handshake. A status register shows which of the two transfers is still in flight.

Register map on `bus_addr`: 0 = key (write only, reads 0), 1 = prescaler code (3 bits), 2 = reload value (12 bits), 3 = status (bit 0 prescaler transfer busy, bit 1 reload transfer busy).

Top module: `keyed_wdog`

## Requirements
- R1: After reset the prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0, and the reset request output is low.
- R2: Until started, the counter does not move and no reset request appears. Writing key 0xCCCC starts the timer with the counter at 0xFFF, so the first request comes 4096 × divide-ratio watchdog cycles after the start, plus the few cycles of synchronizer latency.
- R3: When a prescaler step falls due while the counter is zero, the reset request is high for exactly one watchdog cycle and the counter reloads. Requests then repeat every (reload + 1) × divide-ratio watchdog cycles.
- R4: Writing key 0xAAAA loads the counter from the reload register and restarts the prescaler, whether the timer is running or stopped. Reload keys written more often than the timeout keep the request low.
- R5: Once started, the timer keeps running whatever is written to any register, and whatever the hardware-start input does afterwards.
- R6: Writes to the prescaler and reload registers are ignored unless key 0x5555 has been written since the last 0xAAAA or 0xCCCC key. Either of those two keys locks the registers again.
- R7: The prescaler code is 3 bits. Code k from 0 to 5 divides by 4 × 2^k, and codes 6 and 7 both divide by 256.
- R8: The reload register keeps only bits 11:0 of the written data.
- R9: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1. The bit clears once the value has reached the watchdog domain, within a few cycles of each clock. A write to a register whose busy bit is set is ignored.
- R10: A high level on the hardware-start input starts the timer without any key write.
- R11: A key value other than 0x5555, 0xAAAA or 0xCCCC has no effect on the timer or on the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Register port clock |
| rst_bus_n | input | 1 | Synchronous active-low reset, bus domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 2 | Register select (0 key, 1 prescaler, 2 reload, 3 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| clk_wd | input | 1 | Independent watchdog clock |
| rst_wd_n | input | 1 | Synchronous active-low reset, watchdog domain |
| hw_start_i | input | 1 | Hardware-start strap, level sensitive |
| wd_reset_req_o | output | 1 | One-cycle reset request in the watchdog domain |

## Verification
The assertions rely on three things about the inputs. First, both domain resets are applied together, so the toggle flops on each side of every crossing start equal. Second, a start or reload key is never repeated before the watchdog side has seen the previous one, which takes a few watchdog cycles. Third, the hardware-start input changes only well away from reset release. The directed tests follow these rules: they always reset both domains in one task, they separate repeated keys by tens of watchdog cycles, and they change the strap only while the timer is settled. Timing checks measure the interval between two consecutive requests on the watchdog clock, so they do not depend on crossing latency. The only exception is the first timeout after a start, which is checked against a small window.

// File: rtl/kwd_pkg.sv
// Shared constants for the key-protected watchdog.
// Assumes a 16-bit register port with four word addresses.
package kwd_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [BUS_W-1:0] KEY_RELOAD = 16'hAAAA;
    localparam logic [BUS_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [BUS_W-1:0] KEY_UNLOCK = 16'h5555;

    typedef enum logic [ADDR_W-1:0] {
        REG_KEY    = 2'd0,
        REG_PRESC  = 2'd1,
        REG_RELOAD = 2'd2,
        REG_STATUS = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/kwd_sync.sv
// Multi-flop level synchronizer into the clock domain of clk.
// Assumes d is a level or a toggle that stays put for several clk cycles.
module kwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/kwd_pulse_xfer.sv
// Carries a single-cycle command pulse from one clock domain to another by
// flipping a toggle flop on the source side and edge-detecting the
// synchronized toggle on the destination side.
// Assumes both resets are applied together and that source pulses are spaced
// further apart than the destination's synchronizer latency.
module kwd_pulse_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tgl_src;
    logic tgl_sync;
    logic tgl_seen;

    // Flip the source toggle once per command.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)     tgl_src <= 1'b0;
        else if (src_pulse) tgl_src <= ~tgl_src;
    end

    kwd_sync #(.STAGES(STAGES)) u_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (tgl_src),
        .q     (tgl_sync)
    );

    // Remember the last synchronized toggle level for edge detection.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) tgl_seen <= 1'b0;
        else            tgl_seen <= tgl_sync;
    end

    assign dst_pulse = tgl_sync ^ tgl_seen;

    AST_CMD_PULSE_SINGLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);  // R4
endmodule

// File: rtl/kwd_value_xfer.sv
// Moves a multi-bit configuration value into another clock domain with a
// toggle request and a returned toggle acknowledge. src_busy is high from
// the load until the destination has captured the value.
// Assumes src_data holds steady while src_busy is high and that src_load
// only fires while src_busy is low.
module kwd_value_xfer #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter int           STAGES  = 2
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic         src_load,
    input  logic [W-1:0] src_data,
    output logic         src_busy,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_data
);
    logic req_tgl;
    logic req_sync;
    logic req_seen;
    logic ack_sync;
    logic dst_upd;

    // Flip the request toggle for every accepted load.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)    req_tgl <= 1'b0;
        else if (src_load) req_tgl <= ~req_tgl;
    end

    kwd_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (req_tgl),
        .q     (req_sync)
    );

    // Track the request level seen so far; it doubles as the acknowledge.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) req_seen <= 1'b0;
        else            req_seen <= req_sync;
    end

    assign dst_upd = req_sync ^ req_seen;

    // Capture the held source value when a new request arrives.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n)   dst_data <= RST_VAL;
        else if (dst_upd) dst_data <= src_data;
    end

    kwd_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (req_seen),
        .q     (ack_sync)
    );

    assign src_busy = req_tgl ^ ack_sync;

    AST_LOAD_ONLY_IDLE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_load |-> !src_busy);  // R9
    AST_LOAD_SETS_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_load |=> src_busy);  // R9
endmodule

// File: rtl/kwd_regs.sv
// Bus-domain register file: decodes key writes into start/reload commands
// and the write lock, and holds the prescaler and reload shadows that feed
// the crossings.
// Assumes one write per bus_wr cycle and reads that are combinational.
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PRE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              presc_busy,
    input  logic              reload_busy,
    output logic [PRE_W-1:0]  presc_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              presc_load,
    output logic              reload_load,
    output logic              start_cmd,
    output logic              reload_cmd
);
    reg_addr_e sel;
    logic      key_wr;
    logic      unlocked;

    assign sel         = reg_addr_e'(addr);
    assign key_wr      = wr && (sel == REG_KEY);
    assign start_cmd   = key_wr && (wdata == KEY_START);
    assign reload_cmd  = key_wr && (wdata == KEY_RELOAD);
    assign presc_load  = wr && (sel == REG_PRESC)  && unlocked && !presc_busy;
    assign reload_load = wr && (sel == REG_RELOAD) && unlocked && !reload_busy;

    // Open the configuration registers on the unlock key, close on start or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                      unlocked <= 1'b0;
        else if (key_wr) begin
            if (wdata == KEY_UNLOCK)     unlocked <= 1'b1;
            else if (start_cmd || reload_cmd) unlocked <= 1'b0;
        end
    end

    // Hold the prescaler code written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)          presc_q <= '0;
        else if (presc_load) presc_q <= wdata[PRE_W-1:0];
    end

    // Hold the reload value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)           reload_q <= '1;
        else if (reload_load) reload_q <= wdata[CNT_W-1:0];
    end

    // Select the read data for the addressed register.
    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_KEY:    rdata = '0;
            REG_PRESC:  rdata[PRE_W-1:0] = presc_q;
            REG_RELOAD: rdata[CNT_W-1:0] = reload_q;
            REG_STATUS: rdata[1:0] = {reload_busy, presc_busy};
            default:    rdata = '0;
        endcase
    end

    AST_LOCK_HOLDS_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(presc_q));  // R6
    AST_LOCK_HOLDS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(reload_q));  // R6
    AST_BUSY_HOLDS_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
        presc_busy |=> $stable(presc_q));  // R9
    AST_BUSY_HOLDS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_busy |=> $stable(reload_q));  // R9
endmodule

// File: rtl/kwd_core.sv
// Watchdog-domain timer: run flag, prescaler divider and 12-bit down-counter.
// Raises a one-cycle expire pulse when a step is due at count zero and then
// restarts from the reload value.
// Assumes all inputs are already synchronous to clk.
module kwd_core #(
    parameter int CNT_W        = 12,
    parameter int PRE_W        = 3,
    parameter int DIV_LOG2_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             hw_start,
    input  logic             reload_cmd,
    input  logic [PRE_W-1:0] presc_code,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);
    localparam int PCNT_W   = DIV_LOG2_MAX;
    localparam int SAT_CODE = DIV_LOG2_MAX - 2;

    logic              running;
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] div_m1;
    logic [CNT_W-1:0]  count;
    logic              tick;

    // Map the prescaler code to its terminal count, saturating at the top ratio.
    always_comb begin
        if (int'(presc_code) >= SAT_CODE) div_m1 = '1;
        else div_m1 = (PCNT_W'(4) << presc_code) - PCNT_W'(1);
    end

    assign tick = running && (pcnt >= div_m1);

    // Set the run flag on either start source; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     running <= 1'b0;
        else if (start_cmd || hw_start) running <= 1'b1;
    end

    // Advance the prescaler while running; restart it on a step or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pcnt <= '0;
        else if (reload_cmd || !running || tick) pcnt <= '0;
        else                                     pcnt <= pcnt + PCNT_W'(1);
    end

    // Step the down-counter, reloading on command or after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '1;
        else if (reload_cmd) count <= reload_val;
        else if (tick) begin
            if (count == '0) count <= reload_val;
            else             count <= count - CNT_W'(1);
        end
    end

    // Register the expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) expire <= 1'b0;
        else        expire <= tick && (count == '0) && !reload_cmd;
    end

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);  // R5
    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reload_cmd) |=> $stable(count));  // R2
    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);  // R3
    AST_EXPIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> running);  // R3
endmodule

// File: rtl/keyed_wdog.sv
// Top level of the key-protected watchdog. The bus-domain register file
// feeds two command crossings (start, reload) and two value crossings
// (prescaler, reload), and the watchdog-domain core produces the request.
// Assumes both resets are asserted together.
module keyed_wdog #(
    parameter int CNT_W        = 12,
    parameter int PRE_W        = 3,
    parameter int DIV_LOG2_MAX = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk_bus,
    input  logic        rst_bus_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        clk_wd,
    input  logic        rst_wd_n,
    input  logic        hw_start_i,
    output logic        wd_reset_req_o
);
    logic             presc_busy;
    logic             reload_busy;
    logic [PRE_W-1:0] presc_q;
    logic [CNT_W-1:0] reload_q;
    logic             presc_load;
    logic             reload_load;
    logic             start_cmd_bus;
    logic             reload_cmd_bus;
    logic             start_cmd_wd;
    logic             reload_cmd_wd;
    logic             hw_start_wd;
    logic [PRE_W-1:0] presc_wd;
    logic [CNT_W-1:0] reload_wd;

    kwd_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk         (clk_bus),
        .rst_n       (rst_bus_n),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .rdata       (bus_rdata),
        .presc_busy  (presc_busy),
        .reload_busy (reload_busy),
        .presc_q     (presc_q),
        .reload_q    (reload_q),
        .presc_load  (presc_load),
        .reload_load (reload_load),
        .start_cmd   (start_cmd_bus),
        .reload_cmd  (reload_cmd_bus)
    );

    kwd_value_xfer #(.W(PRE_W), .RST_VAL('0), .STAGES(SYNC_STAGES)) u_presc_xfer (
        .src_clk   (clk_bus),
        .src_rst_n (rst_bus_n),
        .src_load  (presc_load),
        .src_data  (presc_q),
        .src_busy  (presc_busy),
        .dst_clk   (clk_wd),
        .dst_rst_n (rst_wd_n),
        .dst_data  (presc_wd)
    );

    kwd_value_xfer #(.W(CNT_W), .RST_VAL('1), .STAGES(SYNC_STAGES)) u_reload_xfer (
        .src_clk   (clk_bus),
        .src_rst_n (rst_bus_n),
        .src_load  (reload_load),
        .src_data  (reload_q),
        .src_busy  (reload_busy),
        .dst_clk   (clk_wd),
        .dst_rst_n (rst_wd_n),
        .dst_data  (reload_wd)
    );

    kwd_pulse_xfer #(.STAGES(SYNC_STAGES)) u_start_xfer (
        .src_clk   (clk_bus),
        .src_rst_n (rst_bus_n),
        .src_pulse (start_cmd_bus),
        .dst_clk   (clk_wd),
        .dst_rst_n (rst_wd_n),
        .dst_pulse (start_cmd_wd)
    );

    kwd_pulse_xfer #(.STAGES(SYNC_STAGES)) u_reload_cmd_xfer (
        .src_clk   (clk_bus),
        .src_rst_n (rst_bus_n),
        .src_pulse (reload_cmd_bus),
        .dst_clk   (clk_wd),
        .dst_rst_n (rst_wd_n),
        .dst_pulse (reload_cmd_wd)
    );

    kwd_sync #(.STAGES(SYNC_STAGES)) u_hw_start_sync (
        .clk   (clk_wd),
        .rst_n (rst_wd_n),
        .d     (hw_start_i),
        .q     (hw_start_wd)
    );

    kwd_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DIV_LOG2_MAX(DIV_LOG2_MAX)) u_core (
        .clk        (clk_wd),
        .rst_n      (rst_wd_n),
        .start_cmd  (start_cmd_wd),
        .hw_start   (hw_start_wd),
        .reload_cmd (reload_cmd_wd),
        .presc_code (presc_wd),
        .reload_val (reload_wd),
        .expire     (wd_reset_req_o)
    );
endmodule

// File: tb/keyed_wdog_bench.sv
// Directed bench for keyed_wdog: one task per scenario, each checking itself.
module keyed_wdog_bench;
    logic        clk_bus = 1'b0;
    logic        clk_wd  = 1'b0;
    logic        rst_bus_n = 1'b0;
    logic        rst_wd_n  = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        hw_start_i = 1'b0;
    logic        wd_reset_req_o;

    int tests = 0;
    int failed = 0;
    int wd_cyc = 0;
    int pulse_cnt = 0;
    int last_stamp = 0;
    int wide_cnt = 0;
    logic req_prev = 1'b0;

    always #4  clk_bus = ~clk_bus;
    always #10 clk_wd  = ~clk_wd;

    keyed_wdog u_keyed_wdog (
        .clk_bus        (clk_bus),
        .rst_bus_n      (rst_bus_n),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .clk_wd         (clk_wd),
        .rst_wd_n       (rst_wd_n),
        .hw_start_i     (hw_start_i),
        .wd_reset_req_o (wd_reset_req_o)
    );

    always @(posedge clk_wd) wd_cyc <= wd_cyc + 1;

    // Count requests and flag any that last longer than one watchdog cycle.
    always @(negedge clk_wd) begin
        if (wd_reset_req_o) begin
            if (req_prev) wide_cnt = wide_cnt + 1;
            last_stamp = wd_cyc;
            pulse_cnt = pulse_cnt + 1;
        end
        req_prev = wd_reset_req_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk_bus);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_bus);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk_bus);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] s = 16'hFFFF;
        for (int i = 0; i < 80; i++) begin
            bus_read(2'd3, s);
            if (s == 16'h0) break;
        end
        check(s == 16'h0, req, int'(s), 0);
    endtask

    task automatic measure_period(output int iv);
        int n;
        int s;
        n = pulse_cnt;
        wait (pulse_cnt >= n + 2);
        s = last_stamp;
        wait (pulse_cnt >= n + 3);
        iv = last_stamp - s;
    endtask

    task automatic do_reset();
        hw_start_i = 1'b0;
        bus_wr = 1'b0;
        rst_bus_n = 1'b0;
        rst_wd_n = 1'b0;
        repeat (4) @(negedge clk_wd);
        rst_bus_n = 1'b1;
        rst_wd_n = 1'b1;
        repeat (4) @(negedge clk_wd);
    endtask

    // R1 reset values, R2 stopped timer stays quiet.
    task automatic t_reset_state();
        logic [15:0] d;
        int n;
        do_reset();
        bus_read(2'd1, d); check(d == 16'h0,   "R1 presc reset",  int'(d), 0);
        bus_read(2'd2, d); check(d == 16'hFFF, "R1 reload reset", int'(d), 'hFFF);
        bus_read(2'd3, d); check(d == 16'h0,   "R1 status reset", int'(d), 0);
        bus_read(2'd0, d); check(d == 16'h0,   "R1 key reads zero", int'(d), 0);
        check(wd_reset_req_o == 1'b0, "R1 request low", int'(wd_reset_req_o), 0);
        n = pulse_cnt;
        repeat (400) @(negedge clk_wd);
        check(pulse_cnt == n, "R2 no request before start", pulse_cnt - n, 0);
    endtask

    // R6 writes ignored while locked.
    task automatic t_locked();
        logic [15:0] d;
        bus_write(2'd1, 16'h0003);
        bus_write(2'd2, 16'h0123);
        bus_read(2'd1, d); check(d == 16'h0,   "R6 locked presc",  int'(d), 0);
        bus_read(2'd2, d); check(d == 16'hFFF, "R6 locked reload", int'(d), 'hFFF);
        bus_read(2'd3, d); check(d == 16'h0,   "R6 locked no busy", int'(d), 0);
    endtask

    // R8 width, R9 busy flags and writes while busy.
    task automatic t_busy();
        logic [15:0] d;
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'hF00A);
        bus_read(2'd3, d); check(d == 16'h2, "R9 reload busy set", int'(d), 2);
        bus_write(2'd2, 16'h0055);
        wait_idle("R9 reload busy clears");
        bus_read(2'd2, d); check(d == 16'h00A, "R8 R9 reload kept 12 bits, busy write dropped", int'(d), 'h00A);
        bus_write(2'd1, 16'h0002);
        bus_read(2'd3, d); check(d == 16'h1, "R9 presc busy set", int'(d), 1);
        wait_idle("R9 presc busy clears");
        bus_read(2'd1, d); check(d == 16'h2, "R9 presc written", int'(d), 2);
    endtask

    // R2 first timeout from start at 0xFFF with divide by 4; R3 width.
    task automatic t_default_timeout();
        int ws;
        int n;
        int dt;
        do_reset();
        bus_write(2'd0, 16'hCCCC);
        ws = wd_cyc;
        n = pulse_cnt;
        wait (pulse_cnt > n);
        dt = last_stamp - ws;
        check(dt >= 16384 && dt <= 16392, "R2 first timeout", dt, 16384);
        repeat (4) @(negedge clk_wd);
        check(wide_cnt == 0, "R3 single-cycle request", wide_cnt, 0);
    endtask

    // R3 R4 R5 R6 R7 R11 on a running timer.
    task automatic t_running();
        int iv;
        int n;
        logic [15:0] d;
        do_reset();
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'h0001);
        bus_write(2'd2, 16'h000F);
        wait_idle("R9 config settles");
        bus_write(2'd0, 16'hCCCC);
        bus_write(2'd0, 16'hAAAA);
        measure_period(iv);
        check(iv == 128, "R3 R4 R7 period code1 reload15", iv, 128);
        n = pulse_cnt;
        for (int i = 0; i < 10; i++) begin
            repeat (60) @(negedge clk_wd);
            bus_write(2'd0, 16'hAAAA);
        end
        check(pulse_cnt == n, "R4 reload keeps request low", pulse_cnt - n, 0);
        bus_write(2'd1, 16'h0005);
        bus_read(2'd1, d); check(d == 16'h1, "R6 reload key relocks", int'(d), 1);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd0, 16'hCCCC);
        bus_write(2'd1, 16'h0004);
        bus_read(2'd1, d); check(d == 16'h1, "R6 start key relocks", int'(d), 1);
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'hFFFF);
        bus_write(2'd0, 16'h1234);
        measure_period(iv);
        check(iv == 128, "R5 R11 keeps running after other keys", iv, 128);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd0, 16'h1234);
        bus_write(2'd1, 16'h0003);
        bus_read(2'd1, d); check(d == 16'h3, "R11 odd key keeps unlock", int'(d), 3);
        wait_idle("R9 presc settles");
        bus_write(2'd0, 16'hAAAA);
        measure_period(iv);
        check(iv == 512, "R7 code3 divides by 32", iv, 512);
    endtask

    // R7 saturating codes and the minimum timeout; R3 width at period 4.
    task automatic t_codes();
        int iv;
        do_reset();
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'h0000);
        bus_write(2'd1, 16'h0006);
        wait_idle("R9 config settles");
        bus_write(2'd0, 16'hCCCC);
        bus_write(2'd0, 16'hAAAA);
        measure_period(iv);
        check(iv == 256, "R7 code6 divides by 256", iv, 256);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'h0007);
        wait_idle("R9 presc settles");
        bus_write(2'd0, 16'hAAAA);
        measure_period(iv);
        check(iv == 256, "R7 code7 divides by 256", iv, 256);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'h0000);
        wait_idle("R9 presc settles");
        bus_write(2'd0, 16'hAAAA);
        measure_period(iv);
        check(iv == 4, "R3 R7 minimum period", iv, 4);
        check(wide_cnt == 0, "R3 single-cycle at minimum", wide_cnt, 0);
    endtask

    // R10 hardware start, R4 reload while stopped, R5 strap release.
    task automatic t_hw_start();
        int iv;
        int n;
        do_reset();
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'h0003);
        wait_idle("R9 reload settles");
        bus_write(2'd0, 16'hAAAA);
        n = pulse_cnt;
        repeat (200) @(negedge clk_wd);
        check(pulse_cnt == n, "R2 R4 reload alone does not start", pulse_cnt - n, 0);
        hw_start_i = 1'b1;
        measure_period(iv);
        check(iv == 16, "R10 strap starts timer", iv, 16);
        hw_start_i = 1'b0;
        measure_period(iv);
        check(iv == 16, "R5 runs after strap drops", iv, 16);
    endtask

    initial begin
        repeat (190000) @(posedge clk_bus);
        tests++;
        failed++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        t_reset_state();
        t_locked();
        t_busy();
        t_default_timeout();
        t_running();
        t_codes();
        t_hw_start();
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule